// File: doc/BRIEF.md
# Trimmed-Mean Sample Filter

This block reduces a burst of 12-bit converter codes from one temperature sensor to a single filtered value. A per-sensor 3-bit mode chooses how many samples make up a burst and how they are combined: a single code passes straight through, two codes are averaged, or a longer burst is collected, one largest and one smallest code are thrown away, and the remaining codes are averaged. The number of kept codes is always a power of two, so the final division is a right shift that truncates.

Samples arrive on a streaming input qualified by a valid strobe, tagged with the number of the sensor they belong to. A 12-bit configuration word holds one 3-bit mode field per sensor. The field is read when the first code of a burst arrives and is held for the rest of that burst. The running sum, minimum and maximum are kept as the codes stream in, and the result appears with a one-cycle done pulse in the cycle after the final code of the burst. How samples are scheduled and what is done with the result are left to neighbouring logic.

Top module: `tmf_filter`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` is 0 and `res_data` is 0; a burst that was in progress when reset was asserted is discarded.
- R2: Mode code 0 takes one sample and outputs it unchanged, with `res_valid` high in the cycle after that sample is accepted.
- R3: Mode code 1 takes two samples and outputs their sum shifted right by one (truncating).
- R4: Mode code 2 takes four samples, removes one maximum and one minimum, and outputs the remaining sum shifted right by one.
- R5: Mode code 3 takes six samples, removes one maximum and one minimum, and outputs the remaining sum shifted right by two.
- R6: Mode code 4 takes ten samples, removes one maximum and one minimum, and outputs the remaining sum shifted right by three.
- R7: Mode code 5 takes eighteen samples, removes one maximum and one minimum, and outputs the remaining sum shifted right by four.
- R8: Mode codes 6 and 7 behave exactly as mode code 0.
- R9: The mode for sensor s is the field `mode_word[3*s+2 : 3*s]`; it and `sensor_id` are taken from the first sample of a burst, so changes to either during the burst have no effect on its length or result, and `res_sensor` reports the sensor of the first sample.
- R10: When several samples share the largest or the smallest value, exactly one instance of each is removed.
- R11: `res_valid` is high only in the cycle after the final sample of a burst; `res_data` and `res_sensor` hold their values while `res_valid` is low.
- R12: Cycles with `smp_valid` low are not counted as samples; a burst may have idle cycles between its samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_word | input | 12 | Packed 3-bit mode fields, sensor s at bits [3s+2:3s] |
| smp_valid | input | 1 | Sample strobe; one code accepted per cycle it is high |
| smp_data | input | 12 | Converter code |
| sensor_id | input | 2 | Sensor the sample belongs to; used on the first sample of a burst |
| res_valid | output | 1 | One-cycle done pulse |
| res_data | output | 12 | Filtered result |
| res_sensor | output | 2 | Sensor the result belongs to |

## Verification
The bench aims at bursts whose extreme value is repeated, where a design that removes every copy of the largest or smallest code would give a low or high average. It also feeds full-scale codes in the longest burst, which a sum register that is too narrow would wrap, and pairs whose average has a half to drop, which a rounding divider would get wrong. The mode word is cleared after the first sample and the other sensors' fields hold a long mode, so a design that reads the mode each cycle or from the wrong field would finish early or never. Idle gaps and a reset in mid-burst catch a counter that advances without a strobe or keeps stale state.

// File: rtl/tmf_pkg.sv
// Package: shared constants and the burst-plan type for the trimmed-mean filter.
// Assumes mode codes are 3 bits wide and the longest burst is 18 samples.
package tmf_pkg;

    localparam int MODE_W    = 3;
    localparam int MAX_BURST = 18;
    localparam int CNT_W     = $clog2(MAX_BURST + 1);
    localparam int SHIFT_W   = 3;

    // What one burst does: how many samples, whether extremes drop, how far to shift.
    typedef struct packed {
        logic [CNT_W-1:0]   count;
        logic               drop;
        logic [SHIFT_W-1:0] shift;
    } tmf_plan_t;

    // Turn a mode code into its burst plan; spare codes fall back to pass-through.
    function automatic tmf_plan_t plan_of(input logic [MODE_W-1:0] code);
        tmf_plan_t p;
        case (code)
            3'd1:    p = '{count: CNT_W'(2),  drop: 1'b0, shift: SHIFT_W'(1)};
            3'd2:    p = '{count: CNT_W'(4),  drop: 1'b1, shift: SHIFT_W'(1)};
            3'd3:    p = '{count: CNT_W'(6),  drop: 1'b1, shift: SHIFT_W'(2)};
            3'd4:    p = '{count: CNT_W'(10), drop: 1'b1, shift: SHIFT_W'(3)};
            3'd5:    p = '{count: CNT_W'(18), drop: 1'b1, shift: SHIFT_W'(4)};
            default: p = '{count: CNT_W'(1),  drop: 1'b0, shift: SHIFT_W'(0)};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/tmf_mode_select.sv
// Module: picks the mode field of one sensor out of the packed mode word and
// decodes it into a burst plan. Purely combinational.
// Assumes NUM_SENSORS fields of MODE_W bits, sensor 0 in the lowest bits.
module tmf_mode_select
    import tmf_pkg::*;
#(
    parameter int NUM_SENSORS = 4,
    localparam int SEN_W      = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1
) (
    input  logic [NUM_SENSORS*MODE_W-1:0] mode_word,
    input  logic [SEN_W-1:0]              sensor_id,
    output tmf_plan_t                     plan
);

    logic [MODE_W-1:0] field [NUM_SENSORS];

    // Split the packed word into one field per sensor.
    for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_field
        assign field[g] = mode_word[g*MODE_W +: MODE_W];
    end

    // Select the addressed sensor's field and decode it.
    always_comb begin
        plan = plan_of(3'd0);
        for (int i = 0; i < NUM_SENSORS; i++) begin
            if (SEN_W'(i) == sensor_id) plan = plan_of(field[i]);
        end
    end

endmodule

// File: rtl/tmf_accum.sv
// Module: collects one burst, tracking sample count, running sum, minimum and
// maximum. The plan and sensor are captured with the first sample and held.
// Assumes the plan count is at least 1 and at most MAX_BURST.
module tmf_accum
    import tmf_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int SEN_W  = 2,
    localparam int SUM_W = DATA_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SEN_W-1:0]  in_sensor,
    input  tmf_plan_t         live_plan,
    output logic              fire,
    output logic [SUM_W-1:0]  sum_nx,
    output logic [DATA_W-1:0] min_nx,
    output logic [DATA_W-1:0] max_nx,
    output tmf_plan_t         plan_eff,
    output logic [SEN_W-1:0]  sensor_eff,
    output logic              open
);

    logic [CNT_W-1:0]  cnt_q;
    logic [SUM_W-1:0]  sum_q;
    logic [DATA_W-1:0] min_q;
    logic [DATA_W-1:0] max_q;
    tmf_plan_t         plan_q;
    logic [SEN_W-1:0]  sensor_q;
    logic              first;
    logic [CNT_W-1:0]  cnt_inc;

    assign first = (cnt_q == '0);
    assign open  = !first;

    // Fold the incoming sample into the burst statistics.
    always_comb begin
        plan_eff   = first ? live_plan : plan_q;
        sensor_eff = first ? in_sensor : sensor_q;
        cnt_inc    = cnt_q + CNT_W'(1);
        sum_nx     = first ? SUM_W'(in_data) : sum_q + SUM_W'(in_data);
        min_nx     = (first || in_data < min_q) ? in_data : min_q;
        max_nx     = (first || in_data > max_q) ? in_data : max_q;
        fire       = in_valid && (cnt_inc == plan_eff.count);
    end

    // Advance the burst state on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sum_q    <= '0;
            min_q    <= '0;
            max_q    <= '0;
            plan_q   <= '0;
            sensor_q <= '0;
        end else if (in_valid) begin
            cnt_q    <= fire ? '0 : cnt_inc;
            sum_q    <= sum_nx;
            min_q    <= min_nx;
            max_q    <= max_nx;
            plan_q   <= plan_eff;
            sensor_q <= sensor_eff;
        end
    end

endmodule

// File: rtl/tmf_result.sv
// Module: trims the extremes out of the finished sum, divides by shifting,
// and registers the result with a one-cycle done pulse.
// Assumes sum, min and max describe a burst of at least three samples when drop is set.
module tmf_result
    import tmf_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int SEN_W  = 2,
    localparam int SUM_W = DATA_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [SUM_W-1:0]  sum_in,
    input  logic [DATA_W-1:0] min_in,
    input  logic [DATA_W-1:0] max_in,
    input  tmf_plan_t         plan,
    input  logic [SEN_W-1:0]  sensor_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [SEN_W-1:0]  res_sensor
);

    logic [SUM_W-1:0] trimmed;
    logic [SUM_W-1:0] scaled;

    // Remove one maximum and one minimum when the plan asks, then shift.
    always_comb begin
        trimmed = plan.drop ? (sum_in - SUM_W'(max_in) - SUM_W'(min_in)) : sum_in;
        scaled  = trimmed >> plan.shift;
    end

    // Register the result and raise the done pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_data   <= '0;
            res_sensor <= '0;
        end else begin
            res_valid <= fire;
            if (fire) begin
                res_data   <= scaled[DATA_W-1:0];
                res_sensor <= sensor_in;
            end
        end
    end

endmodule

// File: rtl/tmf_filter.sv
// Module: top of the trimmed-mean sample filter. Selects the sensor's mode on
// the first sample of a burst, accumulates the burst, and emits the result.
// Assumes one sample per cycle at most and that a burst is finished before
// samples of another sensor are sent.
module tmf_filter
    import tmf_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int NUM_SENSORS = 4,
    localparam int SEN_W      = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1,
    localparam int SUM_W      = DATA_W + CNT_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SENSORS*MODE_W-1:0] mode_word,
    input  logic                          smp_valid,
    input  logic [DATA_W-1:0]             smp_data,
    input  logic [SEN_W-1:0]              sensor_id,
    output logic                          res_valid,
    output logic [DATA_W-1:0]             res_data,
    output logic [SEN_W-1:0]              res_sensor
);

    tmf_plan_t         live_plan;
    tmf_plan_t         plan_eff;
    logic              fire;
    logic [SUM_W-1:0]  sum_nx;
    logic [DATA_W-1:0] min_nx;
    logic [DATA_W-1:0] max_nx;
    logic [SEN_W-1:0]  sensor_eff;
    logic              burst_open;

    tmf_mode_select #(.NUM_SENSORS(NUM_SENSORS)) u_sel (
        .mode_word (mode_word),
        .sensor_id (sensor_id),
        .plan      (live_plan)
    );

    tmf_accum #(.DATA_W(DATA_W), .SEN_W(SEN_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (smp_valid),
        .in_data    (smp_data),
        .in_sensor  (sensor_id),
        .live_plan  (live_plan),
        .fire       (fire),
        .sum_nx     (sum_nx),
        .min_nx     (min_nx),
        .max_nx     (max_nx),
        .plan_eff   (plan_eff),
        .sensor_eff (sensor_eff),
        .open       (burst_open)
    );

    tmf_result #(.DATA_W(DATA_W), .SEN_W(SEN_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .sum_in     (sum_nx),
        .min_in     (min_nx),
        .max_in     (max_nx),
        .plan       (plan_eff),
        .sensor_in  (sensor_eff),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_sensor (res_sensor)
    );

endmodule

// File: rtl/tmf_filter_chk.sv
// Checker: temporal properties of the trimmed-mean filter, bound to its top.
// Assumes burst_open is high while a burst has accepted samples but not finished.
module tmf_filter_chk #(
    parameter int DATA_W      = 12,
    parameter int NUM_SENSORS = 4,
    parameter int MODE_W      = 3,
    parameter int SEN_W       = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_SENSORS*MODE_W-1:0] mode_word,
    input logic                          smp_valid,
    input logic [DATA_W-1:0]             smp_data,
    input logic [SEN_W-1:0]              sensor_id,
    input logic                          res_valid,
    input logic [DATA_W-1:0]             res_data,
    input logic                          burst_open
);

    logic [MODE_W-1:0] fld;
    assign fld = mode_word[sensor_id*MODE_W +: MODE_W];

    // R1: a reset cycle is followed by no done pulse.
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !res_valid);

    // R11: a done pulse always follows an accepted sample.
    a_r11_pulse_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(smp_valid));

    // R11: the result holds while no pulse is present.
    a_r11_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && $past(rst_n)) |-> $stable(res_data));

    // R2: a pass-through burst finishes one cycle later with the sample itself.
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !burst_open && fld == 3'd0) |=> (res_valid && res_data == $past(smp_data)));

    // R8: spare codes 6 and 7 pass the sample through as well.
    a_r8_spare_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !burst_open && fld >= 3'd6) |=> (res_valid && res_data == $past(smp_data)));

    // R4, R5, R6, R7: multi-sample trimmed modes never finish on their first sample.
    a_r4_no_early_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !burst_open && fld >= 3'd2 && fld <= 3'd5) |=> !res_valid);

    // R3: the two-sample mode never finishes on its first sample.
    a_r3_no_early_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !burst_open && fld == 3'd1) |=> !res_valid);

endmodule

bind tmf_filter tmf_filter_chk #(
    .DATA_W      (DATA_W),
    .NUM_SENSORS (NUM_SENSORS),
    .MODE_W      (tmf_pkg::MODE_W),
    .SEN_W       (SEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_word  (mode_word),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .sensor_id  (sensor_id),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .burst_open (burst_open)
);

// File: tb/tmf_filter_test.sv
`timescale 1ns/1ps
module tmf_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mode_word = '0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic [1:0]  sensor_id = '0;
    logic        res_valid;
    logic [11:0] res_data;
    logic [1:0]  res_sensor;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    tmf_filter uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_word  (mode_word),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .sensor_id  (sensor_id),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_sensor (res_sensor)
    );

    typedef struct packed {
        logic [2:0]        mode;
        logic [1:0]        sen;
        logic [4:0]        n;
        logic [0:17][11:0] s;
        logic [11:0]       expv;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        // R2: single code passes unchanged
        '{mode: 3'd0, sen: 2'd0, n: 5'd1, s: '{0: 12'd100, default: 12'd0}, expv: 12'd100, req: 4'd2},
        // R3: 23/2 truncates to 11
        '{mode: 3'd1, sen: 2'd1, n: 5'd2, s: '{0: 12'd10, 1: 12'd13, default: 12'd0}, expv: 12'd11, req: 4'd3},
        // R4: (180-90-10)/2
        '{mode: 3'd2, sen: 2'd2, n: 5'd4, s: '{0: 12'd50, 1: 12'd10, 2: 12'd90, 3: 12'd30, default: 12'd0}, expv: 12'd40, req: 4'd4},
        // R5: (245-100-5)/4
        '{mode: 3'd3, sen: 2'd3, n: 5'd6, s: '{0: 12'd5, 1: 12'd100, 2: 12'd20, 3: 12'd30, 4: 12'd40, 5: 12'd50, default: 12'd0}, expv: 12'd35, req: 4'd5},
        // R6: (55-10-1)/8 truncates to 5
        '{mode: 3'd4, sen: 2'd0, n: 5'd10, s: '{0: 12'd1, 1: 12'd2, 2: 12'd3, 3: 12'd4, 4: 12'd5, 5: 12'd6, 6: 12'd7, 7: 12'd8, 8: 12'd9, 9: 12'd10, default: 12'd0}, expv: 12'd5, req: 4'd6},
        // R7: full-scale and zero extremes among sixteen 1000s
        '{mode: 3'd5, sen: 2'd1, n: 5'd18, s: '{3: 12'd4095, 11: 12'd0, default: 12'd1000}, expv: 12'd1000, req: 4'd7},
        // R8: code 6 as pass-through
        '{mode: 3'd6, sen: 2'd2, n: 5'd1, s: '{0: 12'd777, default: 12'd0}, expv: 12'd777, req: 4'd8},
        // R8: code 7 as pass-through
        '{mode: 3'd7, sen: 2'd3, n: 5'd1, s: '{0: 12'd4095, default: 12'd0}, expv: 12'd4095, req: 4'd8},
        // R10: repeated extremes, one of each removed: (48-9-7)/4
        '{mode: 3'd3, sen: 2'd2, n: 5'd6, s: '{0: 12'd7, 1: 12'd9, 2: 12'd7, 3: 12'd9, 4: 12'd7, 5: 12'd9, default: 12'd0}, expv: 12'd8, req: 4'd10},
        // R10: all equal at full scale
        '{mode: 3'd2, sen: 2'd0, n: 5'd4, s: '{default: 12'd4095}, expv: 12'd4095, req: 4'd10},
        // R3: large pair, 8189/2 truncates to 4094
        '{mode: 3'd1, sen: 2'd3, n: 5'd2, s: '{0: 12'd4095, 1: 12'd4094, default: 12'd0}, expv: 12'd4094, req: 4'd3}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Drive one burst; mode word is cleared after the first sample (R9).
    task automatic run_vec(input vec_t v);
        logic [11:0] w;
        bit early;
        string rq;
        rq = $sformatf("R%0d", v.req);
        w = {4{3'd4}};
        w[v.sen*3 +: 3] = v.mode;
        early = 1'b0;
        for (int i = 0; i < v.n; i++) begin
            @(negedge clk);
            if (i > 0 && res_valid) early = 1'b1;
            mode_word = (i == 0) ? w : 12'd0;
            sensor_id = (i == 0) ? v.sen : ~v.sen;
            smp_valid = 1'b1;
            smp_data  = v.s[i];
        end
        @(negedge clk);
        smp_valid = 1'b0;
        check(!early, "R11", {rq, " pulse before final sample"}, early, 0);
        check(res_valid, rq, "done pulse after final sample", res_valid, 1);
        check(res_data == v.expv, rq, "result value", res_data, v.expv);
        check(res_sensor == v.sen, "R9", "result sensor", res_sensor, v.sen);
        @(negedge clk);
        check(!res_valid, "R11", "pulse lasts one cycle", res_valid, 0);
        check(res_data == v.expv, "R11", "result held", res_data, v.expv);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet in and after reset
        smp_valid = 1'b1;
        smp_data  = 12'd55;
        repeat (3) @(negedge clk);
        check(!res_valid, "R1", "valid during reset", res_valid, 0);
        smp_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!res_valid, "R1", "valid after reset", res_valid, 0);
        check(res_data == 12'd0, "R1", "data after reset", res_data, 0);

        for (int k = 0; k < NV; k++) run_vec(VT[k]);

        // R12: idle cycles between samples do not count: (20-8-2)/2 = 5
        mode_word = 12'o7727; // sensor 1 field = 2
        sensor_id = 2'd1;
        begin
            logic [11:0] gs [4];
            gs = '{12'd8, 12'd2, 12'd6, 12'd4};
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                smp_valid = 1'b1;
                smp_data  = gs[i];
                @(negedge clk);
                smp_valid = 1'b0;
                if (i < 3) begin
                    @(negedge clk);
                    check(!res_valid, "R12", "no pulse in gap", res_valid, 0);
                end
            end
            check(res_valid && res_data == 12'd5, "R12", "gapped burst result", res_data, 5);
        end

        // R1: reset in mid-burst discards the partial burst
        @(negedge clk);
        mode_word = 12'd3; // sensor 0 field = 3
        sensor_id = 2'd0;
        for (int i = 0; i < 3; i++) begin
            smp_valid = 1'b1;
            smp_data  = 12'd900;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mode_word = 12'd0; // sensor 0 field = 0
        smp_valid = 1'b1;
        smp_data  = 12'd321;
        @(negedge clk);
        smp_valid = 1'b0;
        check(res_valid && res_data == 12'd321, "R1", "fresh burst after reset", res_data, 321);

        // R2: back-to-back pass-through samples each produce a result
        smp_valid = 1'b1;
        smp_data  = 12'd11;
        @(negedge clk);
        smp_data  = 12'd22;
        check(res_valid && res_data == 12'd11, "R2", "first of back-to-back", res_data, 11);
        @(negedge clk);
        smp_valid = 1'b0;
        check(res_valid && res_data == 12'd22, "R2", "second of back-to-back", res_data, 22);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule